// File: doc/BRIEF.md
# Prescaled Compare-Match Timer

This block provides a small set of independent 32-bit up-counters, each driven by its own clock divider and each comparing its count against a programmable match value. When a running counter steps onto its match value, the channel latches a pending flag in a shared status word. The channel also drives an interrupt line whenever that flag is set and the channel's interrupt enable is on. Software reaches every register through a single-cycle register port. Writes take effect at the next clock edge, and reads are combinational.

A typical one-shot event is armed in three steps. Software clears the counter, writes the wanted delay (in divided ticks) to the match register, and then sets the three low control bits. After the interrupt, software clears the pending flag by writing a one to its bit. The counter keeps running and wraps, so a later match only happens after a full trip around the 32-bit range.

Top module: `tick_match_timer`

## Requirements
- R1: After a synchronous active-low reset, every control, match, counter and status register reads zero and every `irq` bit is low.
- R2: Channel n has its control word at byte offset 0x00+4n, its match value at 0x18+4n, its counter at 0x48+4n, and the shared status word sits at 0x60. The control word reads back its bits [31:16] (divider value) and [2:0] (bit 0 run, bit 1 compare enable, bit 2 interrupt enable), and all other bits read zero.
- R3: While bit 0 of the control word is set with divider value P, the counter advances by one every P+1 clocks. The divider restarts while the channel is stopped, so the first advance lands P+1 clocks after the enabling write.
- R4: The counter wraps from 0xFFFFFFFF to 0. A software write to the counter takes effect at the next edge and overrides a tick in that cycle.
- R5: While bit 0 is clear, the counter holds its value.
- R6: Status bit n (bit position n of 0x60) is set on the edge at which channel n's counter steps onto its match value with bits 0 and 1 set. It is set once per arrival, and a software write of the counter does not set it.
- R7: `irq[n]` is high exactly when status bit n and control bit 2 of channel n are both set. Writing zero to a channel's three low control bits drives its `irq` low from the next cycle.
- R8: Writing the status word clears each bit written as one and leaves bits written as zero unchanged, so writing 0xFFFF clears every bit.
- R9: If a clear of status bit n and a new match on channel n fall on the same edge, the bit ends up set.
- R10: Offsets other than those in R2 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected |
| irq | output | 2 | Per-channel interrupt, one bit per channel |

## Verification
A wrong divider phase or a divider that fails to restart shows at the ports as a counter value one step off, or an interrupt one or more divider periods early or late. The bench therefore samples the counter and `irq` on the exact cycle before and after the expected match edge. A status flag that is cleared when it should be kept, or kept when it should be cleared, shows on `irq` and in the status word on the very next cycle. A counter that refires after the match, or that moves while stopped, shows within a few tens of cycles as a spurious `irq` or a changed count.

// File: rtl/tmr_pkg.sv
// Shared constants for the compare-match timer: register offsets and
// control-word bit positions. Assumes a 32-bit data path and byte offsets.
package tmr_pkg;
    localparam int CTRL_OFS  = 'h00;   // channel n control at CTRL_OFS + 4n
    localparam int MATCH_OFS = 'h18;   // channel n match at MATCH_OFS + 4n
    localparam int COUNT_OFS = 'h48;   // channel n counter at COUNT_OFS + 4n
    localparam int STAT_OFS  = 'h60;   // shared pending flags
    localparam int CH_STRIDE = 4;

    // Control-word low field: three enables set or cleared together by software
    localparam int BIT_RUN = 0;
    localparam int BIT_CMP = 1;
    localparam int BIT_IRQ = 2;
    localparam int EN_W    = 3;
endpackage

// File: rtl/tmr_prescaler.sv
// Clock divider for one channel: emits a one-cycle tick every div+1 clocks
// while run is high. Assumes div may change at any time; a phase counter
// already above the new value ticks at once and restarts.
module tmr_prescaler #(
    parameter int PSW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [PSW-1:0] div,
    output logic           tick
);
    logic [PSW-1:0] phase_q;

    assign tick = run && (phase_q >= div);

    // Phase counter: cleared while stopped, wraps after reaching div
    always_ff @(posedge clk) begin
        if (!rst_n)      phase_q <= '0;
        else if (!run)   phase_q <= '0;
        else if (tick)   phase_q <= '0;
        else             phase_q <= phase_q + 1'b1;
    end

    // Two ticks in a row only when the divide value is zero
    assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/tmr_channel.sv
// One timer channel: control word, match register, counter and its compare.
// hit pulses for one cycle with the edge at which the counter steps onto the
// match value. Assumes register writes are one-cycle strobes.
module tmr_channel #(
    parameter int DW  = 32,
    parameter int PSW = DW / 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctrl_we,
    input  logic                     match_we,
    input  logic                     count_we,
    input  logic [DW-1:0]            wdata,
    output logic [PSW-1:0]           div_q,
    output logic [tmr_pkg::EN_W-1:0] en_q,
    output logic [DW-1:0]            match_q,
    output logic [DW-1:0]            count_q,
    output logic                     hit
);
    import tmr_pkg::*;

    logic          tick;
    logic [DW-1:0] count_inc;
    logic          unused_wbits;

    assign unused_wbits = ^wdata[PSW-1:EN_W];
    assign count_inc    = count_q + 1'b1;
    assign hit = tick && en_q[BIT_CMP] && !count_we && (count_inc == match_q);

    tmr_prescaler #(.PSW(PSW)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (en_q[BIT_RUN]),
        .div  (div_q),
        .tick (tick)
    );

    // Control word: divider value in the upper half, enables in the low bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            en_q  <= '0;
        end else if (ctrl_we) begin
            div_q <= wdata[DW-1:DW-PSW];
            en_q  <= wdata[EN_W-1:0];
        end
    end

    // Match register
    always_ff @(posedge clk) begin
        if (!rst_n)        match_q <= '0;
        else if (match_we) match_q <= wdata;
    end

    // Counter: software write first, then a divided tick
    always_ff @(posedge clk) begin
        if (!rst_n)        count_q <= '0;
        else if (count_we) count_q <= wdata;
        else if (tick)     count_q <= count_inc;
    end

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !count_we) |=> (count_q == $past(count_q) + 1'b1));

    assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q[BIT_RUN] && !count_we) |=> $stable(count_q));

    assert_sw_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count_we |=> (count_q == $past(wdata)));
endmodule

// File: rtl/tmr_status.sv
// Shared pending-flag register: one bit per channel, set by a channel hit,
// cleared by writing one. A hit on the same edge as its clear wins.
module tmr_status #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hit,
    input  logic           clr_we,
    input  logic [NCH-1:0] clr_mask,
    output logic [NCH-1:0] flags_q
);
    logic [NCH-1:0] clr;

    assign clr = clr_we ? clr_mask : '0;

    // Write-one-to-clear flags with set priority
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr) | hit;
    end

    assert_hit_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((flags_q & $past(hit)) == $past(hit)));

    assert_match_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit & clr) != '0) |=> ((flags_q & $past(hit & clr)) == $past(hit & clr)));

    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~hit) != '0) |=> ((flags_q & $past(clr & ~hit)) == '0));
endmodule

// File: rtl/tick_match_timer.sv
// Top of the compare-match timer: address decode, read mux, NCH channels and
// the shared status register. Assumes NCH <= 6 so that the channel banks do
// not overlap, and a single-cycle register port with combinational reads.
module tick_match_timer #(
    parameter int NCH = 2,
    parameter int DW  = 32,
    parameter int AW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_sel,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] irq
);
    import tmr_pkg::*;

    localparam int PSW = DW / 2;
    localparam int GAP = DW - PSW - EN_W;

    logic           wr;
    logic [PSW-1:0] div_q   [NCH];
    logic [EN_W-1:0] en_q   [NCH];
    logic [DW-1:0]  match_q [NCH];
    logic [DW-1:0]  count_q [NCH];
    logic [NCH-1:0] hit;
    logic [NCH-1:0] flags_q;
    logic           stat_we;

    assign wr      = bus_sel && bus_we;
    assign stat_we = wr && (bus_addr == AW'(STAT_OFS));

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic ctrl_we, match_we, count_we;

        assign ctrl_we  = wr && (bus_addr == AW'(CTRL_OFS  + CH_STRIDE * g));
        assign match_we = wr && (bus_addr == AW'(MATCH_OFS + CH_STRIDE * g));
        assign count_we = wr && (bus_addr == AW'(COUNT_OFS + CH_STRIDE * g));

        tmr_channel #(.DW(DW), .PSW(PSW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (ctrl_we),
            .match_we(match_we),
            .count_we(count_we),
            .wdata   (bus_wdata),
            .div_q   (div_q[g]),
            .en_q    (en_q[g]),
            .match_q (match_q[g]),
            .count_q (count_q[g]),
            .hit     (hit[g])
        );

        assign irq[g] = flags_q[g] && en_q[g][BIT_IRQ];

        // Clearing the three enables silences the line from the next cycle
        assert_stop_masks_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_we && bus_wdata[EN_W-1:0] == '0) |=> !irq[g]);
    end

    tmr_status #(.NCH(NCH)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .clr_we  (stat_we),
        .clr_mask(bus_wdata[NCH-1:0]),
        .flags_q (flags_q)
    );

    // Read mux: unmapped offsets return zero
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            if (bus_addr == AW'(STAT_OFS)) bus_rdata = DW'(flags_q);
            for (int n = 0; n < NCH; n++) begin
                if (bus_addr == AW'(CTRL_OFS + CH_STRIDE * n))
                    bus_rdata = {div_q[n], {GAP{1'b0}}, en_q[n]};
                if (bus_addr == AW'(MATCH_OFS + CH_STRIDE * n))
                    bus_rdata = match_q[n];
                if (bus_addr == AW'(COUNT_OFS + CH_STRIDE * n))
                    bus_rdata = count_q[n];
            end
        end
    end
endmodule

// File: tb/sim_tick_match_timer.sv
module sim_tick_match_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tick_match_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // {is_write, offset, data, expected read}; runs with all channels stopped
    localparam int NV = 20;
    localparam logic [72:0] VEC [NV] = '{
        {1'b1, 8'h00, 32'hABCDFFF8, 32'h0},
        {1'b0, 8'h00, 32'h0,        32'hABCD0000},
        {1'b1, 8'h04, 32'h00120000, 32'h0},
        {1'b0, 8'h04, 32'h0,        32'h00120000},
        {1'b1, 8'h18, 32'hDEADBEEF, 32'h0},
        {1'b0, 8'h18, 32'h0,        32'hDEADBEEF},
        {1'b1, 8'h1C, 32'h00000100, 32'h0},
        {1'b0, 8'h1C, 32'h0,        32'h00000100},
        {1'b1, 8'h48, 32'h12345678, 32'h0},
        {1'b0, 8'h48, 32'h0,        32'h12345678},
        {1'b1, 8'h4C, 32'hFFFFFFFF, 32'h0},
        {1'b0, 8'h4C, 32'h0,        32'hFFFFFFFF},
        {1'b1, 8'h08, 32'hFFFFFFFF, 32'h0},
        {1'b0, 8'h08, 32'h0,        32'h0},
        {1'b1, 8'h44, 32'h55555555, 32'h0},
        {1'b0, 8'h44, 32'h0,        32'h0},
        {1'b0, 8'h00, 32'h0,        32'hABCD0000},
        {1'b0, 8'h48, 32'h0,        32'h12345678},
        {1'b0, 8'h60, 32'h0,        32'h0},
        {1'b0, 8'h64, 32'h0,        32'h0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq after reset", 32'(irq), 32'h0);
        rd(8'h00, v); check("R1 ctrl0 reset", v, 32'h0);
        rd(8'h4C, v); check("R1 count1 reset", v, 32'h0);
        rd(8'h60, v); check("R1 status reset", v, 32'h0);

        // R2 R5 R10 register table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
            else begin
                rd(VEC[i][71:64], v);
                check($sformatf("R2 R5 R10 table entry %0d", i), v, VEC[i][31:0]);
            end
        end

        // R3 R6 R7 one-shot on channel 0, divide by 4, delay 5
        wr(8'h48, 32'h0);
        wr(8'h18, 32'h5);
        wr(8'h00, 32'h00030007);
        cycles(3);
        rd(8'h48, v); check("R3 no step before P+1 clocks", v, 32'h0);
        cycles(1);
        rd(8'h48, v); check("R3 first step at P+1 clocks", v, 32'h1);
        cycles(15);
        rd(8'h48, v); check("R3 count one edge before match", v, 32'h4);
        check("R6 irq not yet", 32'(irq), 32'h0);
        cycles(1);
        rd(8'h48, v); check("R3 count at match", v, 32'h5);
        check("R7 irq0 on match", 32'(irq), 32'h1);
        rd(8'h60, v); check("R6 status bit0", v, 32'h1);
        wr(8'h60, 32'h1);
        rd(8'h60, v); check("R8 status cleared", v, 32'h0);
        check("R7 irq dropped after clear", 32'(irq), 32'h0);
        cycles(40);
        check("R6 no refire after match", 32'(irq), 32'h0);
        rd(8'h60, v); check("R6 status stays clear", v, 32'h0);
        wr(8'h00, 32'h00030000);
        rd(8'h48, v);
        cycles(10);
        rd(8'h48, v2); check("R5 stopped counter holds", v2, v);

        // R4 wrap on channel 1, divide by 1
        wr(8'h4C, 32'hFFFFFFFE);
        wr(8'h1C, 32'h1);
        wr(8'h04, 32'h00000007);
        rd(8'h4C, v); check("R3 P=0 no step on enable edge", v, 32'hFFFFFFFE);
        cycles(2);
        rd(8'h4C, v); check("R4 wrap to zero", v, 32'h0);
        check("R6 no irq before match", 32'(irq), 32'h0);
        cycles(1);
        check("R6 R7 irq1 after wrap match", 32'(irq), 32'h2);
        wr(8'h04, 32'h0);
        check("R7 stop masks irq1", 32'(irq), 32'h0);
        rd(8'h60, v); check("R7 status kept while masked", v, 32'h2);
        rd(8'h4C, v); check("R4 count after stop", v, 32'h2);
        cycles(5);
        rd(8'h4C, v); check("R5 hold after stop", v, 32'h2);

        // R7 interrupt enable off, then on
        wr(8'h60, 32'h2);
        wr(8'h4C, 32'h0);
        wr(8'h1C, 32'h2);
        wr(8'h04, 32'h00000003);
        cycles(2);
        rd(8'h60, v); check("R6 status set with irq off", v, 32'h2);
        check("R7 irq1 gated by enable", 32'(irq), 32'h0);
        wr(8'h04, 32'h00000007);
        check("R7 irq1 after enable", 32'(irq), 32'h2);

        // R9 clear and match on the same edge, channel 0
        wr(8'h48, 32'h0);
        wr(8'h18, 32'h3);
        wr(8'h00, 32'h00000007);
        cycles(2);
        wr(8'h60, 32'h1);
        rd(8'h60, v); check("R9 match wins over clear", v, 32'h3);

        // R8 zero bits ignored, single-bit clear, clear all
        wr(8'h60, 32'h0);
        rd(8'h60, v); check("R8 zero write keeps flags", v, 32'h3);
        wr(8'h60, 32'h2);
        rd(8'h60, v); check("R8 single bit cleared", v, 32'h1);
        wr(8'h60, 32'h0000FFFF);
        rd(8'h60, v); check("R8 clear all", v, 32'h0);
        check("R8 irq low after clear all", 32'(irq), 32'h0);

        // R1 reset while running
        rst_n = 1'b0;
        cycles(2);
        rst_n = 1'b1;
        check("R1 irq after mid-run reset", 32'(irq), 32'h0);
        rd(8'h00, v); check("R1 ctrl0 cleared", v, 32'h0);
        rd(8'h1C, v); check("R1 match1 cleared", v, 32'h0);
        cycles(5);
        rd(8'h48, v); check("R1 count0 stays zero", v, 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule